// File: doc/BRIEF.md
# Addend Alignment Shifter for a Single-Precision Fused Multiply-Add

This block positions the addend significand of a single-precision fused multiply-add against the 48-bit product, so that a following carry-save adder can combine them directly. It receives the three biased exponents, the stored 23-bit addend fraction, the operation class, the effective-subtract flag and zero flags for the addend and the product. It returns a 73-bit aligned addend and a 24-bit vector of the addend bits that fell below the aligned window. These low bits feed sticky logic.

The alignment distance is never formed as a binary number. The exponents and a constant are reduced to a sum and a carry vector by two 3:2 rows. Each 2-bit segment of that pair is decoded to a one-hot select that ignores incoming carries. A separate carry chain then rotates each select left by one where a carry arrives. The corrected selects drive four 4-way mux stages directly. Saturation and negative distances are read from the same decoded selects.

Zero operands and out-of-range distances are resolved in a bypass path that merges in at the last stage. The same stage inverts the aligned window on effective subtraction. The result is registered, so it appears one clock after the inputs.

Top module: `fma_addend_aligner`

## Requirements
- R1: While `rst` is high at a rising clock edge, all outputs are zero at the next edge. Every other result appears exactly one clock after its inputs are sampled.
- R2: For multiply-add class (`is_madd_i`=1), the shift distance is d = ea + eb − ec − 101. The significand {1, frac} starts with its top bit at bit 72 − d of `aligned_o`. Bits shifted past bit 0 continue into `sticky_o`, from bit 23 downward.
- R3: For add class (`is_madd_i`=0), `exp_b_i` is ignored and d = ea − ec + 26.
- R4: The hidden bit of the addend significand is always taken as 1, whatever the addend exponent, including an exponent of 0.
- R5: A negative distance is clamped to 0. The significand then occupies bits 72..49, and `sticky_o` is zero.
- R6: A distance above 73 saturates. The window part is zero and `sticky_o` holds the whole 24-bit significand. Distances 72 and 73 shift normally.
- R7: On effective subtraction, the 73-bit window is inverted bit by bit after alignment. `sticky_o` is never inverted.
- R8: With the addend-zero flag set, the window is all zeros (all ones on effective subtraction) and `sticky_o` is zero.
- R9: With only the product-zero flag set, the window is {0, significand, 48 zeros}, inverted on effective subtraction. `sticky_o` is zero in this case.
- R10: `true_zero_o` is 1 exactly when both zero flags were set.
- R11: The addend-zero case takes precedence over the product-zero case and over any shift distance, including saturated and negative ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| exp_a_i | input | 8 | Biased exponent of multiplicand A |
| exp_b_i | input | 8 | Biased exponent of multiplier B (multiply-add class only) |
| exp_c_i | input | 8 | Biased exponent of the addend |
| frac_c_i | input | 23 | Stored fraction of the addend |
| is_madd_i | input | 1 | 1 = multiply-add class, 0 = add class |
| eff_sub_i | input | 1 | Effective subtraction |
| zero_c_i | input | 1 | Addend is zero or denormal |
| zero_prod_i | input | 1 | Product is zero |
| aligned_o | output | 73 | Aligned addend window, bit 72 most significant |
| sticky_o | output | 24 | Addend bits below the window |
| true_zero_o | output | 1 | Both addend and product are zero |

## Verification
A fault in the sum/carry decode or in the segment carry correction shows up as the significand landing a multiple of one, four or sixteen positions off. It can also show as a saturation or clamp decision taken on the wrong side of 0 or 73. In either case `aligned_o` and `sticky_o` are wrong one clock after the offending exponents. The stimulus therefore sweeps distances across every segment boundary and the 72/73/74 edge, and it compares every cycle against an integer-arithmetic model. A wrong bypass priority or complement control corrupts whole words at once. These errors are exposed by combining zero flags with saturating, negative and subtracting cases.

// File: rtl/aln_pkg.sv
package aln_pkg;

    localparam int EXP_W  = 8;
    localparam int BIAS   = 127;
    localparam int FRAC_W = 23;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int ALN_W  = 73;
    localparam int STK_W  = SIG_W;
    localparam int TOT_W  = ALN_W + STK_W;
    localparam int PRE_SH = 26;
    localparam int K_ADJ  = PRE_SH - BIAS;
    localparam int SUM_W  = 12;
    localparam int NSEG   = SUM_W / 2;
    localparam int ZP_TOP = SIG_W + 1;

    function automatic int stages_for(input int width);
        int n;
        int reach;
        n = 0;
        reach = 1;
        while (reach <= width) begin
            reach = reach * 4;
            n = n + 1;
        end
        return n;
    endfunction

    localparam int NSTG = stages_for(ALN_W);

    typedef logic [NSEG-1:0][3:0] seg_sel_t;

    typedef enum logic [2:0] {
        BYP_SHIFT,
        BYP_NEG,
        BYP_SAT,
        BYP_ZPROD,
        BYP_ZADD
    } byp_e;

    typedef struct packed {
        logic [ALN_W-1:0] aligned;
        logic [STK_W-1:0] sticky;
        logic             true_zero;
    } aln_out_t;

    function automatic logic [3:0] unary2(input logic [1:0] v);
        return 4'b0001 << v;
    endfunction

    function automatic logic [3:0] rotl1(input logic [3:0] x);
        return {x[2:0], x[3]};
    endfunction

    function automatic logic [3:0] above_mask(input int unsigned lvl);
        logic [3:0] m;
        m = 4'b1111 << (lvl + 1);
        return m;
    endfunction

endpackage

// File: rtl/aln_exp_csa.sv
module aln_exp_csa
    import aln_pkg::*;
(
    input  logic [EXP_W-1:0] ea,
    input  logic [EXP_W-1:0] eb,
    input  logic [EXP_W-1:0] ec,
    input  logic             is_madd,
    output logic [SUM_W-1:0] sum_v,
    output logic [SUM_W-1:0] cry_v
);
    localparam logic [SUM_W-1:0] KC = SUM_W'(K_ADJ + 1);

    logic [SUM_W-1:0] x, y, z, s1, c1;

    always_comb begin
        x  = SUM_W'(ea);
        y  = is_madd ? SUM_W'(eb) : SUM_W'(BIAS);
        z  = ~SUM_W'(ec);
        s1 = x ^ y ^ z;
        c1 = ((x & y) | (x & z) | (y & z)) << 1;
        sum_v = s1 ^ c1 ^ KC;
        cry_v = ((s1 & c1) | (s1 & KC) | (c1 & KC)) << 1;
    end
endmodule

// File: rtl/aln_seg_decode.sv
module aln_seg_decode
    import aln_pkg::*;
(
    input  logic [SUM_W-1:0] sum_v,
    input  logic [SUM_W-1:0] cry_v,
    output seg_sel_t         sel,
    output logic             neg,
    output logic             sat
);
    seg_sel_t          raw;
    logic [NSEG-1:0]   seg_cin;

    genvar j;
    generate
        for (j = 0; j < NSEG; j++) begin : g_seg
            logic p0, g0, p1;
            assign p0 = sum_v[2*j] ^ cry_v[2*j];
            assign g0 = sum_v[2*j] & cry_v[2*j];
            assign p1 = sum_v[2*j+1] ^ cry_v[2*j+1];
            assign raw[j] = unary2({p1 ^ g0, p0});
            assign sel[j] = seg_cin[j] ? rotl1(raw[j]) : raw[j];
        end
    endgenerate

    always_comb begin
        logic c;
        c = 1'b0;
        for (int i = 0; i < SUM_W; i++) begin
            if (i % 2 == 0) seg_cin[i/2] = c;
            c = (sum_v[i] & cry_v[i]) | ((sum_v[i] ^ cry_v[i]) & c);
        end
    end

    always_comb begin
        logic gt;
        gt = 1'b0;
        for (int k = 0; k < NSEG; k++) begin
            int unsigned lvl;
            lvl = (ALN_W >> (2*k)) & 3;
            gt = (|(sel[k] & above_mask(lvl))) | (sel[k][lvl] & gt);
        end
        neg = sel[NSEG-1][2] | sel[NSEG-1][3];
        sat = ~neg & gt;
    end
endmodule

// File: rtl/aln_dshift.sv
module aln_dshift
    import aln_pkg::*;
(
    input  logic [SIG_W-1:0] sig,
    input  seg_sel_t         sel,
    output logic [TOT_W-1:0] shifted
);
    function automatic logic [TOT_W-1:0] stage_mux(input logic [TOT_W-1:0] din,
                                                    input logic [3:0] s4,
                                                    input int step);
        logic [TOT_W-1:0] r;
        r = '0;
        for (int v = 0; v < 4; v++) begin
            if (s4[v]) r = r | (din >> (v * step));
        end
        return r;
    endfunction

    logic [NSTG:0][TOT_W-1:0] stg;

    assign stg[0] = {sig, {(TOT_W-SIG_W){1'b0}}};

    genvar j;
    generate
        for (j = 0; j < NSTG; j++) begin : g_stage
            assign stg[j+1] = stage_mux(stg[j], sel[j], 4**j);
        end
    endgenerate

    assign shifted = stg[NSTG];
endmodule

// File: rtl/fma_addend_aligner.sv
module fma_addend_aligner
    import aln_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        exp_a_i,
    input  logic [7:0]        exp_b_i,
    input  logic [7:0]        exp_c_i,
    input  logic [22:0]       frac_c_i,
    input  logic              is_madd_i,
    input  logic              eff_sub_i,
    input  logic              zero_c_i,
    input  logic              zero_prod_i,
    output logic [72:0]       aligned_o,
    output logic [23:0]       sticky_o,
    output logic              true_zero_o
);
    logic [SUM_W-1:0] sum_v, cry_v;
    seg_sel_t         sel;
    logic             neg, sat;
    logic [SIG_W-1:0] sig;
    logic [TOT_W-1:0] shifted;
    byp_e             byp;
    aln_out_t         nxt, q;
    logic [ALN_W-1:0] pre_al;

    assign sig = {1'b1, frac_c_i};

    aln_exp_csa u_csa (
        .ea      (exp_a_i),
        .eb      (exp_b_i),
        .ec      (exp_c_i),
        .is_madd (is_madd_i),
        .sum_v   (sum_v),
        .cry_v   (cry_v)
    );

    aln_seg_decode u_dec (
        .sum_v (sum_v),
        .cry_v (cry_v),
        .sel   (sel),
        .neg   (neg),
        .sat   (sat)
    );

    aln_dshift u_shf (
        .sig     (sig),
        .sel     (sel),
        .shifted (shifted)
    );

    always_comb begin
        if (zero_c_i)         byp = BYP_ZADD;
        else if (zero_prod_i) byp = BYP_ZPROD;
        else if (neg)         byp = BYP_NEG;
        else if (sat)         byp = BYP_SAT;
        else                  byp = BYP_SHIFT;
    end

    always_comb begin
        nxt.sticky = '0;
        case (byp)
            BYP_ZADD:  pre_al = '0;
            BYP_ZPROD: pre_al = ALN_W'({1'b0, sig}) << (ALN_W - ZP_TOP);
            BYP_NEG:   pre_al = {sig, {(ALN_W-SIG_W){1'b0}}};
            BYP_SAT: begin
                pre_al     = '0;
                nxt.sticky = sig;
            end
            default: begin
                pre_al     = shifted[TOT_W-1 -: ALN_W];
                nxt.sticky = shifted[STK_W-1:0];
            end
        endcase
        nxt.aligned   = pre_al ^ {ALN_W{eff_sub_i}};
        nxt.true_zero = zero_c_i & zero_prod_i;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign aligned_o   = q.aligned;
    assign sticky_o    = q.sticky;
    assign true_zero_o = q.true_zero;
endmodule

// File: rtl/fma_addend_aligner_chk.sv
module fma_addend_aligner_chk
    import aln_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        eff_sub_i,
    input logic        zero_c_i,
    input logic        zero_prod_i,
    input logic [72:0] aligned_o,
    input logic [23:0] sticky_o,
    input logic        true_zero_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (aligned_o == '0 && sticky_o == '0 && !true_zero_o));

    // R10
    true_zero_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (true_zero_o == ($past(zero_c_i) && $past(zero_prod_i))));

    // R8
    zero_addend_chk: assert property (@(posedge clk) disable iff (rst)
        zero_c_i |=> (sticky_o == '0 && aligned_o == {ALN_W{$past(eff_sub_i)}}));

    // R9
    zero_prod_chk: assert property (@(posedge clk) disable iff (rst)
        (!zero_c_i && zero_prod_i) |=> (sticky_o == '0 && aligned_o[ALN_W-1] == $past(eff_sub_i)
                                         && aligned_o[ALN_W-2] != $past(eff_sub_i)));

    // R4
    hidden_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (!zero_c_i && !eff_sub_i) |=> ($countones(aligned_o) + $countones(sticky_o) != 0));
endmodule

bind fma_addend_aligner fma_addend_aligner_chk u_chk (.*);

// File: tb/fma_addend_aligner_tb.sv
module fma_addend_aligner_tb;
    import aln_pkg::*;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  exp_a_i = '0, exp_b_i = '0, exp_c_i = '0;
    logic [22:0] frac_c_i = '0;
    logic        is_madd_i = 1'b0, eff_sub_i = 1'b0, zero_c_i = 1'b0, zero_prod_i = 1'b0;
    logic [72:0] aligned_o;
    logic [23:0] sticky_o;
    logic        true_zero_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fma_addend_aligner u_dut (.*);

    task automatic chk(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model(output logic [72:0] al, output logic [23:0] st, output logic tz);
        int d;
        logic [96:0] ext;
        d = int'(exp_a_i) + (is_madd_i ? int'(exp_b_i) : BIAS) - int'(exp_c_i) + PRE_SH - BIAS;
        if (d < 0)  d = 0;
        if (d > 73) d = 73;
        ext = {1'b1, frac_c_i, 73'd0} >> d;
        al = ext[96:24];
        st = ext[23:0];
        if (zero_c_i) begin
            al = '0; st = '0;
        end else if (zero_prod_i) begin
            al = {1'b0, 1'b1, frac_c_i, 48'd0}; st = '0;
        end
        if (eff_sub_i) al = ~al;
        tz = zero_c_i & zero_prod_i;
    endtask

    task automatic apply(input string tag, input int ea, input int eb, input int ec,
                         input logic [22:0] fr, input bit madd, input bit sub,
                         input bit zc, input bit zp);
        logic [72:0] eal;
        logic [23:0] est;
        logic        etz;
        exp_a_i = 8'(ea); exp_b_i = 8'(eb); exp_c_i = 8'(ec);
        frac_c_i = fr; is_madd_i = madd; eff_sub_i = sub;
        zero_c_i = zc; zero_prod_i = zp;
        model(eal, est, etz);
        @(negedge clk);
        chk(tag, "aligned", 128'(aligned_o), 128'(eal));
        chk(tag, "sticky", 128'(sticky_o), 128'(est));
        chk("R10", "true_zero", 128'(true_zero_o), 128'(etz));
    endtask

    function automatic string classify(int ea, int eb, int ec, bit madd, bit sub, bit zc, bit zp);
        int d;
        d = ea + (madd ? eb : BIAS) - ec + PRE_SH - BIAS;
        if (zc)      return "R8";
        if (zp)      return "R9";
        if (d < 0)   return "R5";
        if (d > 73)  return "R6";
        if (sub)     return "R7";
        return madd ? "R2" : "R3";
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: registers cleared by reset
        chk("R1", "aligned", 128'(aligned_o), 128'd0);
        chk("R1", "sticky", 128'(sticky_o), 128'd0);
        chk("R1", "true_zero", 128'(true_zero_o), 128'd0);

        apply("R2", 127, 127, 127, 23'h2AAAAA, 1, 0, 0, 0);
        apply("R2", 100, 100, 99, 23'h7FFFFF, 1, 0, 0, 0);
        apply("R2", 150, 150, 159, 23'h123456, 1, 0, 0, 0);
        apply("R2", 150, 150, 147, 23'h654321, 1, 0, 0, 0);
        apply("R2", 150, 150, 135, 23'h0F0F0F, 1, 0, 0, 0);
        apply("R6", 150, 150, 127, 23'h5A5A5A, 1, 0, 0, 0);
        apply("R6", 150, 150, 126, 23'h5A5A5A, 1, 0, 0, 0);
        apply("R6", 150, 150, 125, 23'h5A5A5A, 1, 0, 0, 0);
        apply("R6", 255, 255, 0, 23'h3C3C3C, 1, 0, 0, 0);
        apply("R3", 140, 3, 120, 23'h111111, 0, 0, 0, 0);
        apply("R3", 140, 250, 120, 23'h111111, 0, 0, 0, 0);
        apply("R5", 10, 10, 200, 23'h777777, 1, 0, 0, 0);
        apply("R5", 0, 0, 255, 23'h000001, 1, 1, 0, 0);
        apply("R4", 60, 60, 0, 23'h000000, 1, 0, 0, 0);
        apply("R7", 127, 127, 123, 23'h0ABCDE, 1, 1, 0, 0);
        apply("R7", 150, 150, 100, 23'h0ABCDE, 1, 1, 0, 0);
        apply("R8", 127, 127, 127, 23'h7FFFFF, 1, 0, 1, 0);
        apply("R8", 127, 127, 127, 23'h7FFFFF, 1, 1, 1, 0);
        apply("R9", 127, 127, 127, 23'h2468AC, 1, 0, 0, 1);
        apply("R9", 10, 10, 250, 23'h2468AC, 1, 1, 0, 1);
        apply("R11", 255, 255, 0, 23'h7FFFFF, 1, 0, 1, 1);
        apply("R11", 0, 0, 255, 23'h7FFFFF, 1, 1, 1, 1);
        apply("R11", 150, 150, 100, 23'h13579B, 1, 1, 1, 0);

        // R1: reset in the middle of traffic
        exp_a_i = 8'd150; exp_b_i = 8'd150; exp_c_i = 8'd140; zero_c_i = 1'b0;
        zero_prod_i = 1'b1; eff_sub_i = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "aligned", 128'(aligned_o), 128'd0);
        chk("R1", "true_zero", 128'(true_zero_o), 128'd0);
        rst = 1'b0;

        for (int n = 0; n < 4000; n++) begin
            int ea, eb, ec;
            bit madd, sub, zc, zp;
            logic [22:0] fr;
            ea   = $urandom_range(255, 0);
            eb   = $urandom_range(255, 0);
            madd = ($urandom_range(3, 0) != 0);
            sub  = $urandom_range(1, 0);
            zc   = ($urandom_range(15, 0) == 0);
            zp   = ($urandom_range(15, 0) == 0);
            fr   = 23'($urandom);
            if ($urandom_range(3, 0) != 0) begin
                ec = ea + (madd ? eb : BIAS) + PRE_SH - BIAS - $urandom_range(80, 0);
                if (ec < 0)   ec = 0;
                if (ec > 255) ec = 255;
            end else begin
                ec = $urandom_range(255, 0);
            end
            apply(classify(ea, eb, ec, madd, sub, zc, zp), ea, eb, ec, fr, madd, sub, zc, zp);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule